// File: doc/BRIEF.md
# Chained-Descriptor DMA Channel

A single DMA channel that moves through a list of transfer nodes held in memory. Each node takes 32 bytes and carries a link word, a byte count, a source address, a destination address and a configuration word. The channel fetches these words through a simple read port. It counts the node's bytes down in beats, then follows the link to the next node. A link that points back at an earlier node gives a ring that repeats without end, which suits streaming buffers. Data movement is modelled only by the countdown and the address updates. No data path is present.

Software starts the channel in one of two ways. It can write the first node's fields straight into the channel registers and then write a configuration with the enable bit set. Or it can write the link register and pulse `kick`, and the channel fetches the first node from memory. The channel signals the end of a node with a single-cycle pulse when that node asks for one, and the end of the whole list with another pulse. It also shows the live remaining count, the link word, the addresses and the configuration of the node being worked on, so software can compute how much is left.

Top module: `lli_dma_chan`

## Requirements
- R1: After reset, `busy`, `mem_req`, `tc_node` and `tc_chain` are low and `cur_cnt` is zero.
- R2: While idle, a register write sets one field, chosen by `reg_sel`: 0 is the link word, 1 the count (low 16 bits), 2 the source, 3 the destination and 4 the configuration. A configuration write with bit 0 set starts the node held in the registers, and `busy` is high from the next cycle.
- R3: A `kick` pulse while idle fetches a node from the link register with its low 5 bits cleared. It reads offsets 0x00, 0x10, 0x14, 0x18 and 0x1C, in that order, as the link, count, source, destination and configuration. `mem_req` and `mem_addr` stay stable until `mem_rvalid` arrives.
- R4: Each enabled transfer cycle removes min(remaining, (B+1) << W) bytes from the count. B is configuration bits 23:20 and W is bits 15:12. `cur_cnt` shows the remaining bytes, and a node may hold up to 0x1FFC bytes.
- R5: The source address advances by the bytes moved when configuration bit 31 is set. The destination address advances the same way when bit 30 is set. Otherwise each address stays fixed.
- R6: When a node's count reaches zero, the channel checks bit 1 of the link word. If the bit is set, it fetches the next node at the link word with its low 5 bits cleared. If the bit is clear, it pulses `tc_chain` for one cycle, drops `busy` and goes idle.
- R7: `tc_node` pulses for one cycle at the end of each node whose configuration bit 1 is set. The pulse and `tc_chain` both fall in the cycle in which the count reaches zero.
- R8: While active, a configuration write changes only the enable bit. Clearing the bit pauses the channel: `busy` goes low, and the count and addresses hold. Setting it again resumes from the same point.
- R9: While active, writes to the link, count, source and destination registers have no effect on the transfer.
- R10: A list whose last link points back to its head runs without end, giving only `tc_node` pulses and never `tc_chain`.
- R11: `cur_ptr` shows the link word of the node in progress, which is also its value when that node's end pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 link, 1 count, 2 source, 3 destination, 4 configuration) |
| reg_wdata | input | 32 | Register write data |
| kick | input | 1 | Start by fetching the node at the link register |
| mem_req | output | 1 | Node word read request |
| mem_addr | output | 32 | Node word byte address |
| mem_rvalid | input | 1 | Read data valid; completes the pending request |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Channel active and enabled |
| tc_node | output | 1 | Per-node end pulse |
| tc_chain | output | 1 | End-of-list pulse |
| cur_cnt | output | 16 | Remaining bytes of the current node |
| cur_ptr | output | 32 | Link word of the current node |
| cur_src | output | 32 | Current source address |
| cur_dst | output | 32 | Current destination address |
| cur_cfg | output | 32 | Current configuration word |

## Verification
The assertions assume three things about the inputs. `mem_rvalid` rises only while `mem_req` is high. Pauses are written while the channel is transferring, not while it is fetching. Node words are not changed while they are in flight. The memory model in the bench answers only pending requests, with a fixed delay of at least one idle cycle, and its node contents are written before `kick`. Every pause and resume in the stimulus is issued during the countdown of a directly started node.

// File: rtl/lli_dma_chan.sv
module lli_dma_chan #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DESC_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          kick,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic          tc_node,
  output logic          tc_chain,
  output logic [CW-1:0] cur_cnt,
  output logic [AW-1:0] cur_ptr,
  output logic [AW-1:0] cur_src,
  output logic [AW-1:0] cur_dst,
  output logic [31:0]   cur_cfg
);
  localparam int ALIGN = $clog2(DESC_BYTES);
  localparam int LAST_WORD = 4;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER} st_t;

  st_t           st_q;
  logic [2:0]    widx_q;
  logic [AW-1:0] base_q, ptr_q, src_q, dst_q;
  logic [31:0]   cfg_q;
  logic [CW-1:0] cnt_q;
  logic          tcn_q, tcc_q;

  logic [AW-1:0] beat_bytes, cnt_ext, moved, fetch_off, link_base;
  logic          last_beat, run, cfg_wr;

  assign run        = cfg_q[0];
  assign cfg_wr     = reg_we && (reg_sel == 3'd4);
  assign beat_bytes = (AW'(cfg_q[23:20]) + AW'(1)) << cfg_q[15:12];
  assign cnt_ext    = AW'(cnt_q);
  assign last_beat  = cnt_ext <= beat_bytes;
  assign moved      = last_beat ? cnt_ext : beat_bytes;
  assign fetch_off  = (widx_q == 3'd0) ? '0 : AW'(32'd12 + {27'd0, widx_q, 2'b00});
  assign link_base  = {ptr_q[AW-1:ALIGN], ALIGN'(0)};

  assign mem_req  = (st_q == S_FETCH);
  assign mem_addr = base_q + fetch_off;
  assign busy     = (st_q != S_IDLE) && run;
  assign tc_node  = tcn_q;
  assign tc_chain = tcc_q;
  assign cur_cnt  = cnt_q;
  assign cur_ptr  = ptr_q;
  assign cur_src  = src_q;
  assign cur_dst  = dst_q;
  assign cur_cfg  = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      widx_q <= '0;
      base_q <= '0;
      ptr_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      cfg_q  <= '0;
      cnt_q  <= '0;
      tcn_q  <= 1'b0;
      tcc_q  <= 1'b0;
    end else begin
      tcn_q <= 1'b0;
      tcc_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (reg_we) begin
            unique case (reg_sel)
              3'd0: ptr_q <= AW'(reg_wdata);
              3'd1: cnt_q <= reg_wdata[CW-1:0];
              3'd2: src_q <= AW'(reg_wdata);
              3'd3: dst_q <= AW'(reg_wdata);
              3'd4: begin
                cfg_q <= reg_wdata;
                if (reg_wdata[0]) st_q <= S_XFER;
              end
              default: ;
            endcase
          end else if (kick) begin
            base_q   <= link_base;
            widx_q   <= '0;
            cfg_q[0] <= 1'b1;
            st_q     <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (cfg_wr) cfg_q[0] <= reg_wdata[0];
          if (mem_rvalid) begin
            unique case (widx_q)
              3'd0: ptr_q <= AW'(mem_rdata);
              3'd1: cnt_q <= mem_rdata[CW-1:0];
              3'd2: src_q <= AW'(mem_rdata);
              3'd3: dst_q <= AW'(mem_rdata);
              default: cfg_q <= mem_rdata;
            endcase
            if (widx_q == 3'(LAST_WORD)) st_q <= S_XFER;
            else widx_q <= widx_q + 3'd1;
          end
        end
        S_XFER: begin
          if (cfg_wr) cfg_q[0] <= reg_wdata[0];
          if (run) begin
            cnt_q <= last_beat ? '0 : cnt_q - CW'(moved);
            if (cfg_q[31]) src_q <= src_q + moved;
            if (cfg_q[30]) dst_q <= dst_q + moved;
            if (last_beat) begin
              tcn_q <= cfg_q[1];
              if (ptr_q[1]) begin
                base_q <= link_base;
                widx_q <= '0;
                st_q   <= S_FETCH;
              end else begin
                tcc_q <= 1'b1;
                st_q  <= S_IDLE;
              end
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  a_r4_cnt_down: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_XFER) && $past(st_q == S_XFER) |-> cnt_q <= $past(cnt_q));

  a_r6_chain_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tc_chain |-> !busy && !mem_req);

  a_r7_end_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_node || tc_chain) |-> cur_cnt == '0);

  a_r8_pause_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_XFER) && !run |=> $stable(cnt_q) && $stable(src_q) && $stable(dst_q));

  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    tc_node |=> !tc_node);
endmodule

// File: tb/lli_dma_chan_bench.sv
module lli_dma_chan_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        kick = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, tc_node, tc_chain;
  logic [15:0] cur_cnt;
  logic [31:0] cur_ptr, cur_src, cur_dst, cur_cfg;

  lli_dma_chan u_lli_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .kick(kick), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy),
    .tc_node(tc_node), .tc_chain(tc_chain), .cur_cnt(cur_cnt),
    .cur_ptr(cur_ptr), .cur_src(cur_src), .cur_dst(cur_dst), .cur_cfg(cur_cfg));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        n;
    logic        c;
    logic [31:0] ptr;
    logic [31:0] src;
    logic [31:0] dst;
    string       tag;
  } ev_t;

  ev_t exp_q[$];
  int  nchk = 0;
  int  nfail = 0;
  int  lat = 1;
  int  wcnt = 0;
  int  cycles = 0;
  logic [31:0] mem [int unsigned];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mkcfg(bit en, bit irq, bit sinc, bit dinc,
                                        int w, int b);
    return {sinc, dinc, 2'b00, 4'(b), 4'(b), 4'(w), 4'(w), 8'h00, 2'b01, irq, en};
  endfunction

  function automatic void push(logic n, logic c, logic [31:0] p, logic [31:0] s,
                               logic [31:0] d, string tag);
    ev_t e;
    e.n = n; e.c = c; e.ptr = p; e.src = s; e.dst = d; e.tag = tag;
    exp_q.push_back(e);
  endfunction

  function automatic void put_node(int unsigned a, logic [31:0] p, logic [31:0] cn,
                                   logic [31:0] s, logic [31:0] d, logic [31:0] cf);
    mem[a>>2] = p; mem[(a+16)>>2] = cn; mem[(a+20)>>2] = s;
    mem[(a+24)>>2] = d; mem[(a+28)>>2] = cf;
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0; wcnt = 0;
    end else if (mem_rvalid) begin
      mem_rvalid = 1'b0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_rvalid = 1'b1;
        mem_rdata = mem.exists(mem_addr >> 2) ? mem[mem_addr >> 2] : 32'h0;
      end else wcnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && (tc_node || tc_chain)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected end pulse", {30'd0, tc_node, tc_chain}, 32'h0);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(tc_node == e.n, e.tag, "tc_node", 32'(tc_node), 32'(e.n));
        chk(tc_chain == e.c, e.tag, "tc_chain", 32'(tc_chain), 32'(e.c));
        chk(cur_ptr == e.ptr, "R11", "link word at end", cur_ptr, e.ptr);
        chk(cur_src == e.src, "R5", "source at end", cur_src, e.src);
        chk(cur_dst == e.dst, "R5", "destination at end", cur_dst, e.dst);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_empty(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin @(negedge clk); n++; end
    chk(exp_q.size() == 0, req, "events pending", 32'(exp_q.size()), 32'h0);
  endtask

  task automatic count_busy(input string req, input int expv);
    int k = 0;
    while (busy && k < 5000) begin @(negedge clk); k++; end
    chk(k == expv, req, "transfer cycles", 32'(k), 32'(expv));
  endtask

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !tc_node && !tc_chain, "R1", "control outputs",
        {28'd0, busy, mem_req, tc_node, tc_chain}, 32'h0);
    chk(cur_cnt == 16'h0, "R1", "count", 32'(cur_cnt), 32'h0);
    rst_n = 1'b1;

    // R2, R4, R5: direct start, 16-byte beats, 100 bytes
    wr(3'd0, 32'h0); wr(3'd1, 32'd100); wr(3'd2, 32'h1000); wr(3'd3, 32'h2000);
    push(1'b0, 1'b1, 32'h0, 32'h1064, 32'h2064, "R6");
    wr(3'd4, mkcfg(1, 0, 1, 1, 2, 3));
    chk(busy, "R2", "busy after start", 32'(busy), 32'h1);
    chk(cur_cnt == 16'd100, "R2", "count before first beat", 32'(cur_cnt), 32'd100);
    @(negedge clk);
    chk(cur_cnt == 16'd84, "R4", "count after one beat", 32'(cur_cnt), 32'd84);
    count_busy("R4", 6);
    wait_empty("R6");

    // R4, R5: 1-byte beats, only source increments
    wr(3'd1, 32'd5); wr(3'd2, 32'h1100); wr(3'd3, 32'h2200);
    push(1'b0, 1'b1, 32'h0, 32'h1105, 32'h2200, "R6");
    wr(3'd4, mkcfg(1, 0, 1, 0, 0, 0));
    count_busy("R4", 5);
    wait_empty("R6");

    // R3, R6, R7, R11: fetched three-node list
    lat = 3;
    put_node(32'h100, 32'h142, 32'd40, 32'h4000, 32'h9000, mkcfg(1, 1, 1, 0, 2, 1));
    put_node(32'h140, 32'h182, 32'd24, 32'h5000, 32'h9000, mkcfg(1, 0, 1, 0, 1, 0));
    put_node(32'h180, 32'h0, 32'h1FFC, 32'h6000, 32'h7000, mkcfg(1, 1, 1, 1, 3, 15));
    push(1'b1, 1'b0, 32'h142, 32'h4028, 32'h9000, "R7");
    push(1'b1, 1'b1, 32'h0, 32'h6000 + 32'h1FFC, 32'h7000 + 32'h1FFC, "R7");
    wr(3'd0, 32'h100);
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    chk(mem_req && mem_addr == 32'h100, "R3", "first fetch address", mem_addr, 32'h100);
    begin
      int n = 0;
      while (!(cur_ptr == 32'h0 && busy && !mem_req) && n < 2000) begin @(negedge clk); n++; end
    end
    chk(cur_cnt == 16'h1FFC, "R4", "maximum count loaded", 32'(cur_cnt), 32'h1FFC);
    @(negedge clk);
    chk(cur_cnt == 16'h1F7C, "R4", "128-byte beat", 32'(cur_cnt), 32'h1F7C);
    wait_empty("R6");
    lat = 1;

    // R8, R9: pause, ignored writes, resume
    wr(3'd0, 32'h0); wr(3'd1, 32'd64); wr(3'd2, 32'h3000); wr(3'd3, 32'h3800);
    push(1'b0, 1'b1, 32'h0, 32'h3040, 32'h3840, "R9");
    wr(3'd4, mkcfg(1, 0, 1, 1, 2, 0));
    @(negedge clk); @(negedge clk);
    wr(3'd4, mkcfg(0, 0, 1, 1, 2, 0));
    chk(!busy, "R8", "busy while paused", 32'(busy), 32'h0);
    held = cur_cnt;
    wr(3'd2, 32'hDEAD0000); wr(3'd1, 32'd1000); wr(3'd0, 32'h102);
    repeat (4) @(negedge clk);
    chk(cur_cnt == held, "R8", "count frozen", 32'(cur_cnt), 32'(held));
    chk(cur_ptr == 32'h0, "R9", "link word unchanged", cur_ptr, 32'h0);
    wr(3'd4, mkcfg(1, 0, 1, 1, 2, 0));
    chk(busy, "R8", "busy after resume", 32'(busy), 32'h1);
    wait_empty("R9");

    // R10: ring of two nodes, three turns then reset
    put_node(32'h200, 32'h222, 32'd16, 32'hA000, 32'hB000, mkcfg(1, 1, 1, 0, 2, 0));
    put_node(32'h220, 32'h202, 32'd8, 32'hA010, 32'hB000, mkcfg(1, 1, 1, 0, 2, 0));
    for (int i = 0; i < 3; i++) begin
      push(1'b1, 1'b0, 32'h222, 32'hA010, 32'hB000, "R10");
      push(1'b1, 1'b0, 32'h202, 32'hA018, 32'hB000, "R10");
    end
    wr(3'd0, 32'h200);
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
    wait_empty("R10");
    chk(busy, "R10", "still running after three turns", 32'(busy), 32'h1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && cur_cnt == 16'h0, "R1", "state after reset", {31'd0, busy}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule